// File: doc/BRIEF.md
# Synchronized Phase-Frequency Detector Controller

This block is the digital heart of one phase-locked loop. It runs on the reference clock and watches two single-cycle edge pulses: one from the loop's feedback (main) divider and one from its reference divider. Whichever edge comes first opens a charge-pump request. A reference edge that leads opens a source request (`up`). A main edge that leads opens a sink request (`down`). The request stays open until the lagging edge arrives. Both requests are then held together for a fixed minimum overlap and closed at the same time. Because of this overlap, a phase error close to zero still yields a pulse of defined width, which keeps the detector gain linear around lock.

A per-loop enable starts and stops the loop without glitches. While the loop is off, the detector is cleared and a resync output holds both dividers in their start state. Turning the loop on releases the dividers and the detector together, so no random phase error is left over from the disabled period. Turning it off waits for any open pump request to complete normally, and only then parks the loop. A two-bit gain request is registered and turned into a pump gain code and a nominal current in microamps. The loop can be built as a wide-range loop with four gain steps or a narrow-range loop with two.

Top module: `pfd_loop_ctrl`

## Requirements
- R1: With the loop running and both requests idle, a `ref_edge` sampled at a clock edge sets `up` after that edge, and `down` stays low.
- R2: With the loop running and both requests idle, a `main_edge` sampled at a clock edge sets `down` after that edge, and `up` stays low.
- R3: A single open request stays high until the opposite edge is sampled, so the leading request lasts the edge spacing in cycles plus the overlap.
- R4: Once `up` and `down` are both high, they stay high together for exactly MIN_OVERLAP (default 2) cycles and then both fall. Edges that arrive in the same cycle give a pulse of exactly that width on both outputs.
- R5: An edge on the side whose request is already open, or any edge during the overlap, has no effect: the pulse timing does not change and no request is left open afterwards.
- R6: After reset and whenever the loop is off, `up` and `down` are low, `div_resync` is high, `loop_active` is low, and edges are ignored.
- R7: When `loop_on` is sampled high while the loop is off, `div_resync` falls and `loop_active` rises after that edge. An edge sampled in the same cycle does not open a request.
- R8: When `loop_on` is sampled low while a request is open, that request runs on until the opposite edge, followed by its overlap. `div_resync` rises one cycle after both requests fall, and no new request opens in the meantime.
- R9: When `loop_on` is sampled low with both requests idle, `div_resync` is high and `loop_active` is low after that edge.
- R10: In a wide-range loop (LOOP_KIND=0), `gain_code` = {`gain_hi`,`gain_dbl`} one cycle after the inputs are sampled. `pump_ua` is 470, 840, 1410 or 2480 for codes 00, 01, 10 and 11, and the reset code is 00.
- R11: In a narrow-range loop (LOOP_KIND=1), `gain_hi` has no effect: `gain_code` = {0,`gain_dbl`} and `pump_ua` is 470 or 840.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loop_on | input | 1 | Loop enable |
| ref_edge | input | 1 | One-cycle pulse from the reference divider |
| main_edge | input | 1 | One-cycle pulse from the main divider |
| gain_hi | input | 1 | High-current gain request bit |
| gain_dbl | input | 1 | Doubled-current gain request bit |
| up | output | 1 | Charge-pump source request |
| down | output | 1 | Charge-pump sink request |
| div_resync | output | 1 | Holds the dividers in their start state |
| loop_active | output | 1 | Loop is running and accepting edges |
| gain_code | output | 2 | Registered pump gain code |
| pump_ua | output | 12 | Nominal pump current in microamps |

## Verification
The hardest case to reach from the ports is a turn-off that lands in the middle of an open request. The bench first opens a request with a lone reference edge. It then drops `loop_on` while that request is waiting, and sends a further reference edge that the loop must ignore. Only after that does it deliver the closing main edge. The bench checks that the request survives the turn-off, that the overlap still completes, and that `div_resync` rises only one cycle after both requests fall. The turn-on case, in which an edge arrives in the same cycle the enable is sampled, is also driven on purpose.

// File: rtl/pfdsync_pkg.sv
// Package: shared types and the gain-to-current mapping for the
// synchronized phase-frequency detector controller.
// Assumes currents fit in UA_W bits.
package pfdsync_pkg;

    // Loop sequencing states.
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } loop_state_t;

    localparam int UA_W = 12;

    // Nominal pump current for a gain code, in microamps.
    function automatic logic [UA_W-1:0] pump_ua_of(input logic [1:0] code);
        logic [UA_W-1:0] ua;
        case (code)
            2'b00:   ua = UA_W'(470);
            2'b01:   ua = UA_W'(840);
            2'b10:   ua = UA_W'(1410);
            default: ua = UA_W'(2480);
        endcase
        return ua;
    endfunction

endpackage

// File: rtl/loop_sequencer.sv
// Module: loop_sequencer
// Controls loop on/off. The loop is OFF (dividers held in resync, detector
// cleared) or RUN (edges accepted). A turn-off request that arrives while
// a pump request is open goes through DRAIN, where only closing edges are
// accepted, and reaches OFF once both requests have fallen.
// Assumes busy comes from the detector's registered outputs.
module loop_sequencer
    import pfdsync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic loop_on,
    input  logic busy,
    output logic start_ok,
    output logic hold_clear,
    output logic div_resync,
    output logic active
);

    loop_state_t state_q;
    loop_state_t state_d;

    // Next-state selection from the enable and the detector activity.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_OFF:   if (loop_on) state_d = ST_RUN;
            ST_RUN:   if (!loop_on) state_d = busy ? ST_DRAIN : ST_OFF;
            ST_DRAIN: if (!busy) state_d = ST_OFF;
            default:  state_d = ST_OFF;
        endcase
    end

    // State register with synchronous reset into OFF.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Output decode for the detector and the divider resync.
    always_comb begin
        start_ok   = (state_q == ST_RUN) && loop_on;
        hold_clear = (state_q == ST_OFF);
        div_resync = (state_q == ST_OFF);
        active     = (state_q == ST_RUN);
    end

    // R8: a turn-off with an open request must drain, not cut it.
    a_r8_drain_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !loop_on && busy) |=> (state_q == ST_DRAIN));

    // R7: enabling from OFF releases resync and raises active.
    a_r7_turn_on: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && loop_on) |=> (active && !div_resync));

endmodule

// File: rtl/pfd_core.sv
// Module: pfd_core
// Three-state phase-frequency detector that works on edge pulses sampled
// by the reference clock. The leading edge opens its request. The lagging
// edge opens the other one. Both then stay high for MIN_OVERLAP cycles
// and are closed together. New requests open only while start_ok is high.
// A closing edge is always accepted.
// Assumes edge pulses last one clock cycle.
module pfd_core #(
    parameter int MIN_OVERLAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_clear,
    input  logic start_ok,
    input  logic ref_edge,
    input  logic main_edge,
    output logic up,
    output logic down
);

    localparam int CNT_W = (MIN_OVERLAP < 2) ? 1 : $clog2(MIN_OVERLAP);
    localparam logic [CNT_W-1:0] OVL_LAST = CNT_W'(MIN_OVERLAP - 1);

    logic             up_q;
    logic             dn_q;
    logic [CNT_W-1:0] ovl_cnt;

    // Request flops and overlap timer.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_clear) begin
            up_q    <= 1'b0;
            dn_q    <= 1'b0;
            ovl_cnt <= '0;
        end else if (up_q && dn_q) begin
            if (ovl_cnt == OVL_LAST) begin
                up_q    <= 1'b0;
                dn_q    <= 1'b0;
                ovl_cnt <= '0;
            end else begin
                ovl_cnt <= ovl_cnt + 1'b1;
            end
        end else begin
            if (!up_q && ref_edge && (start_ok || dn_q))  up_q <= 1'b1;
            if (!dn_q && main_edge && (start_ok || up_q)) dn_q <= 1'b1;
        end
    end

    assign up   = up_q;
    assign down = dn_q;

    // R3: a lone source request is held until the main edge arrives.
    a_r3_up_held: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && !dn_q && !main_edge && !hold_clear) |=> up_q);

    // R3: a lone sink request is held until the reference edge arrives.
    a_r3_dn_held: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_q && !up_q && !ref_edge && !hold_clear) |=> dn_q);

    // R4: the overlap ends after its final counted cycle.
    a_r4_overlap_end: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && dn_q && ovl_cnt == OVL_LAST) |=> (!up_q && !dn_q));

    // R8: with starts blocked, an idle detector stays idle.
    a_r8_no_new_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_q && !dn_q && !start_ok) |=> (!up_q && !dn_q));

endmodule

// File: rtl/gain_select.sv
// Module: gain_select
// Registers the gain request and maps it to a pump gain code and a
// nominal current. LOOP_KIND 0 builds the four-step wide-range mapping.
// LOOP_KIND 1 builds the two-step narrow-range mapping, which ignores
// gain_hi.
module gain_select
    import pfdsync_pkg::*;
#(
    parameter int LOOP_KIND = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gain_hi,
    input  logic            gain_dbl,
    output logic [1:0]      gain_code,
    output logic [UA_W-1:0] pump_ua
);

    logic [1:0] code_d;
    logic [1:0] code_q;

    generate
        if (LOOP_KIND == 0) begin : g_wide
            // Wide range: both request bits form the code.
            always_comb code_d = {gain_hi, gain_dbl};

            // R10: the highest request gives the largest current.
            a_r10_top_step: assert property (@(posedge clk) disable iff (!rst_n)
                (gain_hi && gain_dbl) |=> (pump_ua == UA_W'(2480)));
        end else begin : g_narrow
            // Narrow range: only the doubling bit matters.
            always_comb code_d = {1'b0, gain_dbl};

            // R11: the high-current bit alone leaves the base current.
            a_r11_hi_ignored: assert property (@(posedge clk) disable iff (!rst_n)
                (gain_hi && !gain_dbl) |=> (pump_ua == UA_W'(470)));
        end
    endgenerate

    // Gain code register.
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= 2'b00;
        else        code_q <= code_d;
    end

    assign gain_code = code_q;
    assign pump_ua   = pump_ua_of(code_q);

endmodule

// File: rtl/pfd_loop_ctrl.sv
// Module: pfd_loop_ctrl (top)
// One loop's detector controller: sequencer, detector core and gain
// mapping. All outputs come from registers or decode registered state.
// Assumes all inputs are synchronous to clk.
module pfd_loop_ctrl
    import pfdsync_pkg::*;
#(
    parameter int LOOP_KIND   = 0,
    parameter int MIN_OVERLAP = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            loop_on,
    input  logic            ref_edge,
    input  logic            main_edge,
    input  logic            gain_hi,
    input  logic            gain_dbl,
    output logic            up,
    output logic            down,
    output logic            div_resync,
    output logic            loop_active,
    output logic [1:0]      gain_code,
    output logic [UA_W-1:0] pump_ua
);

    logic start_ok;
    logic hold_clear;
    logic busy;

    assign busy = up | down;

    loop_sequencer i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .loop_on    (loop_on),
        .busy       (busy),
        .start_ok   (start_ok),
        .hold_clear (hold_clear),
        .div_resync (div_resync),
        .active     (loop_active)
    );

    pfd_core #(.MIN_OVERLAP(MIN_OVERLAP)) i_pfd (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_clear (hold_clear),
        .start_ok   (start_ok),
        .ref_edge   (ref_edge),
        .main_edge  (main_edge),
        .up         (up),
        .down       (down)
    );

    gain_select #(.LOOP_KIND(LOOP_KIND)) i_gain (
        .clk       (clk),
        .rst_n     (rst_n),
        .gain_hi   (gain_hi),
        .gain_dbl  (gain_dbl),
        .gain_code (gain_code),
        .pump_ua   (pump_ua)
    );

    // R6: while dividers are held, no pump request is open.
    a_r6_resync_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        div_resync |-> (!up && !down));

    // R9: an idle running loop that is disabled parks immediately.
    a_r9_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_active && !loop_on && !up && !down) |=> (div_resync && !loop_active));

endmodule

// File: tb/test_pfd_loop_ctrl.sv
module test_pfd_loop_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        loop_on = 1'b0;
    logic        ref_edge = 1'b0;
    logic        main_edge = 1'b0;
    logic        gain_hi = 1'b0;
    logic        gain_dbl = 1'b0;
    logic        up, down, div_resync, loop_active;
    logic [1:0]  gain_code;
    logic [11:0] pump_ua;
    logic        up_n, down_n, resync_n, active_n;
    logic [1:0]  gain_code_n;
    logic [11:0] pump_ua_n;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfd_loop_ctrl #(.LOOP_KIND(0)) i_pfd_loop_ctrl (
        .clk(clk), .rst_n(rst_n), .loop_on(loop_on), .ref_edge(ref_edge),
        .main_edge(main_edge), .gain_hi(gain_hi), .gain_dbl(gain_dbl),
        .up(up), .down(down), .div_resync(div_resync), .loop_active(loop_active),
        .gain_code(gain_code), .pump_ua(pump_ua)
    );

    pfd_loop_ctrl #(.LOOP_KIND(1)) i_pfd_loop_ctrl_nar (
        .clk(clk), .rst_n(rst_n), .loop_on(loop_on), .ref_edge(ref_edge),
        .main_edge(main_edge), .gain_hi(gain_hi), .gain_dbl(gain_dbl),
        .up(up_n), .down(down_n), .div_resync(resync_n), .loop_active(active_n),
        .gain_code(gain_code_n), .pump_ua(pump_ua_n)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance one clock; we end on the falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_pump(input string req, input int u, input int d);
        check({req, " up"}, int'(up), u);
        check({req, " down"}, int'(down), d);
    endtask

    task automatic t_reset();
        tick(); tick();
        check_pump("R6 reset", 0, 0);
        check("R6 reset resync", int'(div_resync), 1);
        check("R6 reset active", int'(loop_active), 0);
        check("R10 reset code", int'(gain_code), 0);
        check("R10 reset ua", int'(pump_ua), 470);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_enable_with_edge();
        loop_on = 1'b1; ref_edge = 1'b1;
        tick();
        ref_edge = 1'b0;
        check("R7 resync released", int'(div_resync), 0);
        check("R7 active", int'(loop_active), 1);
        check_pump("R7 same-cycle edge ignored", 0, 0);
        tick();
        check_pump("R7 still idle", 0, 0);
    endtask

    task automatic t_ref_leads();
        ref_edge = 1'b1; tick(); ref_edge = 1'b0;
        check_pump("R1 ref leads", 1, 0);
        tick(); tick();
        check_pump("R3 up held", 1, 0);
        main_edge = 1'b1; tick(); main_edge = 1'b0;
        check_pump("R4 overlap 1", 1, 1);
        tick();
        check_pump("R4 overlap 2", 1, 1);
        tick();
        check_pump("R3 both closed", 0, 0);
        tick();
        check_pump("R3 stays idle", 0, 0);
    endtask

    task automatic t_main_leads();
        main_edge = 1'b1; tick(); main_edge = 1'b0;
        check_pump("R2 main leads", 0, 1);
        tick();
        check_pump("R3 down held", 0, 1);
        ref_edge = 1'b1; tick(); ref_edge = 1'b0;
        check_pump("R4 overlap a", 1, 1);
        tick();
        check_pump("R4 overlap b", 1, 1);
        tick();
        check_pump("R2 closed", 0, 0);
    endtask

    task automatic t_simultaneous();
        ref_edge = 1'b1; main_edge = 1'b1; tick();
        ref_edge = 1'b0; main_edge = 1'b0;
        check_pump("R4 zero error 1", 1, 1);
        tick();
        check_pump("R4 zero error 2", 1, 1);
        tick();
        check_pump("R4 zero error end", 0, 0);
    endtask

    task automatic t_repeat_edges();
        ref_edge = 1'b1; tick();
        check_pump("R5 first ref", 1, 0);
        tick(); ref_edge = 1'b0;
        check_pump("R5 repeat ref", 1, 0);
        main_edge = 1'b1; tick(); main_edge = 1'b0;
        check_pump("R5 overlap opens", 1, 1);
        ref_edge = 1'b1; main_edge = 1'b1; tick();
        ref_edge = 1'b0; main_edge = 1'b0;
        check_pump("R5 edges in overlap", 1, 1);
        tick();
        check_pump("R5 closes on time", 0, 0);
        tick();
        check_pump("R5 nothing left open", 0, 0);
    endtask

    task automatic t_idle_off();
        loop_on = 1'b0; tick();
        check("R9 resync", int'(div_resync), 1);
        check("R9 active", int'(loop_active), 0);
        ref_edge = 1'b1; tick(); ref_edge = 1'b0;
        check_pump("R6 ref ignored", 0, 0);
        main_edge = 1'b1; tick(); main_edge = 1'b0;
        check_pump("R6 main ignored", 0, 0);
        check("R6 resync held", int'(div_resync), 1);
    endtask

    task automatic t_drain();
        loop_on = 1'b1; tick();
        check("R7 re-enable", int'(loop_active), 1);
        ref_edge = 1'b1; tick(); ref_edge = 1'b0;
        check_pump("R8 request open", 1, 0);
        loop_on = 1'b0; tick();
        check_pump("R8 not cut", 1, 0);
        check("R8 inactive", int'(loop_active), 0);
        check("R8 resync waits", int'(div_resync), 0);
        ref_edge = 1'b1; tick(); ref_edge = 1'b0;
        check_pump("R8 extra ref ignored", 1, 0);
        main_edge = 1'b1; tick(); main_edge = 1'b0;
        check_pump("R8 closing overlap 1", 1, 1);
        tick();
        check_pump("R8 closing overlap 2", 1, 1);
        tick();
        check_pump("R8 closed", 0, 0);
        check("R8 resync not yet", int'(div_resync), 0);
        tick();
        check("R8 resync after drain", int'(div_resync), 1);
        ref_edge = 1'b1; tick(); ref_edge = 1'b0;
        check_pump("R8 no new start", 0, 0);
    endtask

    task automatic t_gain();
        for (int c = 0; c < 4; c++) begin
            gain_hi = c[1]; gain_dbl = c[0];
            tick();
            check("R10 code", int'(gain_code), c);
            check("R10 ua", int'(pump_ua), (c == 0) ? 470 : (c == 1) ? 840 : (c == 2) ? 1410 : 2480);
            check("R11 narrow code", int'(gain_code_n), c % 2);
            check("R11 narrow ua", int'(pump_ua_n), (c % 2 == 1) ? 840 : 470);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_enable_with_edge();
        t_ref_leads();
        t_main_leads();
        t_simultaneous();
        t_repeat_edges();
        t_idle_off();
        t_drain();
        t_gain();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule